// File: doc/BRIEF.md
# Dual Synthesizer Divider Register Port

This block holds the divider settings of two frequency synthesizers, one for the pixel clock and one for the loop clock. Each synthesizer has three byte slots: the feedback divider N, the reference divider M and the post-divider P. A byte-wide host bus reaches them through a shared pointer register and two data ports, one per synthesizer. The pointer carries a separate slot index for each synthesizer. Each index steps on only when its own data port is accessed, so the host can set the pointer to zero and then stream N, M and P through one port.

The analog loop itself is not modelled. In its place each synthesizer has a counter. A P-slot write with the stop bit clear arms the counter. The lock flag rises a fixed number of cycles later. The host polls that flag in bit 6 of the P-slot read value. A P-slot write with the stop bit set halts the synthesizer and drops its lock. The usual stop values are 0x3C for pixel and 0x70 for loop. Reads of N and M return the stored bytes unchanged, so a saved setting can be written back later. The latched bytes and the two lock flags are also driven out as ports.

Top module: `dual_synth_regs`

## Requirements
- R1: After reset every stored byte is 0, both slot indices are 0, both lock flags are 0, and no lock appears until a P slot is written.
- R2: Address 0 is the pointer. A write sets the pixel index from bits 1:0 and the loop index from bits 5:4, and the other bits are ignored. A field value of 3 is stored as 0. A read returns the loop index in bits 5:4, the pixel index in bits 1:0 and zeros elsewhere.
- R3: A write to a data port stores the byte in the slot given by that synthesizer's index (0 = N, 1 = M, 2 = P) and advances the index 0, 1, 2, 0. Address 1 is the pixel port and address 2 is the loop port.
- R4: A read of a data port returns the selected slot and advances the index in the same way. N and M read back exactly as written.
- R5: A read of the P slot returns the stored P byte with bit 6 replaced by that synthesizer's lock flag.
- R6: A P-slot write with bit 5 clear arms the synthesizer. Its lock flag becomes 1 exactly LOCK_CYCLES clock cycles after the write edge and stays 1 until that synthesizer is written again.
- R7: A P-slot write with bit 5 set (for example 0x3C or 0x70) clears the lock at once and keeps it 0 until a later P write re-arms.
- R8: On an armed synthesizer, any write to N, M or P clears the lock and restarts the full LOCK_CYCLES count.
- R9: Accesses to one synthesizer's port leave the other synthesizer's bytes, lock flag and index unchanged.
- R10: Address 3 is reserved. It reads as 0, and writes to it change no state.
- R11: The stored N, M and P bytes of both synthesizers appear on the output ports in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | 0 pointer, 1 pixel data, 2 loop data, 3 reserved |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| pix_n_o | output | DW | Pixel N byte |
| pix_m_o | output | DW | Pixel M byte |
| pix_p_o | output | DW | Pixel P byte as stored |
| pix_lock_o | output | 1 | Pixel lock flag |
| lp_n_o | output | DW | Loop N byte |
| lp_m_o | output | DW | Loop M byte |
| lp_p_o | output | DW | Loop P byte as stored |
| lp_lock_o | output | 1 | Loop lock flag |

## Verification
The bench streams full N, M, P triples through each port from pointer zero. It reads them back from pointer zero, and with the pointer parked at slot 2 it checks the wrap to N. A read from the wrong slot or a broken wrap shows up as a byte mismatch. Pointer values mix different indices for the two synthesizers, contain field value 3 and set the ignored bits. This separates the two fields and shows that an access to one port leaves the other index alone. The lock flag is sampled one cycle before and one cycle after the expected edge, after an arming write, after a stop write and after a restart write to N. This catches an off-by-one in the count, a stop that does not take hold, and a count that does not restart.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef logic [1:0] slot_t;

  localparam slot_t SLOT_N = 2'd0;
  localparam slot_t SLOT_M = 2'd1;
  localparam slot_t SLOT_P = 2'd2;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_PIX  = 2'd1,
    SEL_LOOP = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_SYN = 2;
  localparam int unsigned FLD_STRIDE = 4;

  function automatic slot_t slot_next(slot_t s);
    return (s == SLOT_P) ? SLOT_N : slot_t'(s + 2'd1);
  endfunction

  function automatic slot_t slot_clean(logic [1:0] v);
    return (v == 2'd3) ? SLOT_N : slot_t'(v);
  endfunction

endpackage

// File: rtl/dsr_ptr.sv
module dsr_ptr
  import dsr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  slot_t [NUM_SYN-1:0]  fld_i,
  input  logic  [NUM_SYN-1:0]  adv_i,
  output slot_t [NUM_SYN-1:0]  idx_o
);

  for (genvar g = 0; g < NUM_SYN; g++) begin : g_idx
    slot_t idx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        idx_q <= SLOT_N;
      else if (wr_i)      idx_q <= slot_clean(fld_i[g]);
      else if (adv_i[g])  idx_q <= slot_next(idx_q);
    end
    assign idx_o[g] = idx_q;
  end

endmodule

// File: rtl/dsr_synth.sv
module dsr_synth
  import dsr_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned LOCK_CYCLES = 64,
  parameter int unsigned STOP_BIT    = 5,
  parameter int unsigned LOCK_BIT    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  slot_t         slot_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] n_o,
  output logic [DW-1:0] m_o,
  output logic [DW-1:0] p_o,
  output logic          lock_o,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_CYCLES - 1);

  logic [DW-1:0] n_q, m_q, p_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q, lock_q;
  logic [DW-1:0] p_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
      m_q <= '0;
      p_q <= '0;
    end else if (wr_i) begin
      case (slot_i)
        SLOT_N:  n_q <= wdata_i;
        SLOT_M:  m_q <= wdata_i;
        SLOT_P:  p_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // Stand-in for the analog loop: settle counter gated by armed state.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (wr_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
      if (slot_i == SLOT_P) armed_q <= ~wdata_i[STOP_BIT];
    end else if (armed_q && !lock_q) begin
      if (cnt_q == CNT_LAST) lock_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    p_rd           = p_q;
    p_rd[LOCK_BIT] = lock_q;
    case (slot_i)
      SLOT_N:  rdata_o = n_q;
      SLOT_M:  rdata_o = m_q;
      SLOT_P:  rdata_o = p_rd;
      default: rdata_o = '0;
    endcase
  end

  assign n_o    = n_q;
  assign m_o    = m_q;
  assign p_o    = p_q;
  assign lock_o = lock_q;

endmodule

// File: rtl/dual_synth_regs.sv
module dual_synth_regs
  import dsr_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned LOCK_CYCLES = 64,
  parameter int unsigned STOP_BIT    = 5,
  parameter int unsigned LOCK_BIT    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] pix_n_o,
  output logic [DW-1:0] pix_m_o,
  output logic [DW-1:0] pix_p_o,
  output logic          pix_lock_o,
  output logic [DW-1:0] lp_n_o,
  output logic [DW-1:0] lp_m_o,
  output logic [DW-1:0] lp_p_o,
  output logic          lp_lock_o
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  slot_t [NUM_SYN-1:0]         idx;
  slot_t [NUM_SYN-1:0]         fld;
  logic  [NUM_SYN-1:0]         acc;
  logic  [NUM_SYN-1:0][DW-1:0] n_w, m_w, p_w, rd_w;
  logic  [NUM_SYN-1:0]         lock_w;
  logic  [DW-1:0]              ptr_rd;

  for (genvar g = 0; g < NUM_SYN; g++) begin : g_syn
    localparam reg_sel_e PORT = (g == 0) ? SEL_PIX : SEL_LOOP;

    assign fld[g] = slot_t'(wdata_i[g*FLD_STRIDE +: 2]);
    assign acc[g] = req_i && (sel == PORT);

    dsr_synth #(
      .DW          (DW),
      .LOCK_CYCLES (LOCK_CYCLES),
      .STOP_BIT    (STOP_BIT),
      .LOCK_BIT    (LOCK_BIT)
    ) u_syn (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .slot_i  (idx[g]),
      .wr_i    (acc[g] && we_i),
      .wdata_i (wdata_i),
      .n_o     (n_w[g]),
      .m_o     (m_w[g]),
      .p_o     (p_w[g]),
      .lock_o  (lock_w[g]),
      .rdata_o (rd_w[g])
    );
  end

  dsr_ptr u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (req_i && we_i && (sel == SEL_PTR)),
    .fld_i  (fld),
    .adv_i  (acc),
    .idx_o  (idx)
  );

  always_comb begin
    ptr_rd = '0;
    for (int g = 0; g < NUM_SYN; g++) ptr_rd[g*FLD_STRIDE +: 2] = idx[g];
  end

  always_comb begin
    case (sel)
      SEL_PTR:  rdata_o = ptr_rd;
      SEL_PIX:  rdata_o = rd_w[0];
      SEL_LOOP: rdata_o = rd_w[1];
      default:  rdata_o = '0;
    endcase
  end

  assign pix_n_o    = n_w[0];
  assign pix_m_o    = m_w[0];
  assign pix_p_o    = p_w[0];
  assign pix_lock_o = lock_w[0];
  assign lp_n_o     = n_w[1];
  assign lp_m_o     = m_w[1];
  assign lp_p_o     = p_w[1];
  assign lp_lock_o  = lock_w[1];

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int unsigned DW       = 8,
  parameter int unsigned STOP_BIT = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] pix_n_o,
  input logic [DW-1:0] pix_p_o,
  input logic          pix_lock_o,
  input logic [DW-1:0] lp_p_o,
  input logic          lp_lock_o
);

  logic ptr_wr, pix_wr, lp_wr, rsvd_rd, rsvd_wr;
  assign ptr_wr  = req_i && we_i && (addr_i == 2'd0);
  assign pix_wr  = req_i && we_i && (addr_i == 2'd1);
  assign lp_wr   = req_i && we_i && (addr_i == 2'd2);
  assign rsvd_rd = req_i && !we_i && (addr_i == 2'd3);
  assign rsvd_wr = req_i && we_i && (addr_i == 2'd3);

  assert_pix_wr_drops_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_wr |=> !pix_lock_o);
  assert_lp_wr_drops_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_wr |=> !lp_lock_o);

  assert_pix_lock_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_lock_o && !pix_wr) |=> pix_lock_o);
  assert_lp_lock_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_lock_o && !lp_wr) |=> lp_lock_o);

  assert_pix_stopped_unlocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_p_o[STOP_BIT] |-> !pix_lock_o);
  assert_lp_stopped_unlocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_p_o[STOP_BIT] |-> !lp_lock_o);

  assert_lp_wr_keeps_pix_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_wr |=> ($stable(pix_p_o) && $stable(pix_n_o)));

  assert_ptr_wr_keeps_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |=> ($stable(pix_n_o) && $stable(pix_p_o) && $stable(lp_p_o)));

  assert_rsvd_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_rd |-> (rdata_o == '0));
  assert_rsvd_wr_no_effect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_wr |=> ($stable(pix_p_o) && $stable(lp_p_o) && $stable(pix_n_o)));

endmodule

bind dual_synth_regs dsr_checker #(
  .DW       (DW),
  .STOP_BIT (STOP_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .pix_n_o    (pix_n_o),
  .pix_p_o    (pix_p_o),
  .pix_lock_o (pix_lock_o),
  .lp_p_o     (lp_p_o),
  .lp_lock_o  (lp_lock_o)
);

// File: tb/tb_dual_synth_regs.sv
module tb_dual_synth_regs;

  localparam int CLK_PERIOD = 10;
  localparam int LOCK       = 8;
  localparam logic [1:0] A_PTR = 2'd0, A_PIX = 2'd1, A_LP = 2'd2, A_RSV = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pix_n, pix_m, pix_p, lp_n, lp_m, lp_p;
  logic       pix_lock, lp_lock;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_synth_regs #(.DW(8), .LOCK_CYCLES(LOCK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .pix_n_o(pix_n), .pix_m_o(pix_m), .pix_p_o(pix_p), .pix_lock_o(pix_lock),
    .lp_n_o(lp_n), .lp_m_o(lp_m), .lp_p_o(lp_p), .lp_lock_o(lp_lock)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #(CLK_PERIOD/4);
    d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  // Called right after an arming write returns; checks both sides of the lock edge.
  task automatic lock_edge(input string tag, input bit pix);
    repeat (LOCK - 1) @(negedge clk);
    chk({tag, " before edge"}, {7'b0, pix ? pix_lock : lp_lock}, 8'h00);
    @(negedge clk);
    chk({tag, " at edge"}, {7'b0, pix ? pix_lock : lp_lock}, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 pix_n", pix_n, 8'h00);
    chk("R1 pix_m", pix_m, 8'h00);
    chk("R1 pix_p", pix_p, 8'h00);
    chk("R1 lp_p", lp_p, 8'h00);
    bus_rd(A_PTR, d);
    chk("R1 ptr", d, 8'h00);
    repeat (LOCK + 3) @(negedge clk);
    chk("R1 no lock", {6'b0, lp_lock, pix_lock}, 8'h00);
    bus_rd(A_PIX, d);
    chk("R4 reset N read", d, 8'h00);
    bus_rd(A_PTR, d);
    chk("R4 read advances pix idx", d, 8'h01);
  endtask

  task automatic t_pixel_program();
    logic [7:0] d;
    bus_wr(A_PTR, 8'h00);
    bus_wr(A_PIX, 8'h12);
    bus_wr(A_PIX, 8'h34);
    bus_wr(A_PIX, 8'h05);
    chk("R11 pix_n", pix_n, 8'h12);
    chk("R11 pix_m", pix_m, 8'h34);
    chk("R11 pix_p", pix_p, 8'h05);
    lock_edge("R6 pix", 1'b1);
    chk("R9 lp_n untouched", lp_n, 8'h00);
    chk("R9 lp_lock untouched", {7'b0, lp_lock}, 8'h00);
    bus_wr(A_PTR, 8'h00);
    bus_rd(A_PIX, d); chk("R4 N read", d, 8'h12);
    bus_rd(A_PIX, d); chk("R4 M read", d, 8'h34);
    bus_rd(A_PIX, d); chk("R5 P read with lock", d, 8'h45);
  endtask

  task automatic t_ptr_fields();
    logic [7:0] d;
    bus_wr(A_PTR, 8'h13); bus_rd(A_PTR, d); chk("R2 field 3 -> 0", d, 8'h10);
    bus_wr(A_PTR, 8'hE6); bus_rd(A_PTR, d); chk("R2 both slot P", d, 8'h22);
    bus_wr(A_PTR, 8'hCC); bus_rd(A_PTR, d); chk("R2 ignored bits", d, 8'h00);
  endtask

  task automatic t_loop_iso();
    logic [7:0] d;
    bus_wr(A_PTR, 8'h01);
    bus_wr(A_LP, 8'h0A);
    bus_wr(A_LP, 8'h0B);
    bus_wr(A_LP, 8'h01);
    chk("R11 lp_n", lp_n, 8'h0A);
    chk("R11 lp_m", lp_m, 8'h0B);
    chk("R11 lp_p", lp_p, 8'h01);
    lock_edge("R6 loop", 1'b0);
    bus_rd(A_PTR, d);
    chk("R3 loop wrap, R9 pix idx kept", d, 8'h01);
    chk("R9 pix_m kept", pix_m, 8'h34);
    chk("R9 pix_lock kept", {7'b0, pix_lock}, 8'h01);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    bus_wr(A_PTR, 8'h02);
    bus_rd(A_PIX, d); chk("R5 P slot read", d, 8'h45);
    bus_rd(A_PIX, d); chk("R3 index wraps to N", d, 8'h12);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    bus_wr(A_PTR, 8'h22);
    bus_wr(A_PIX, 8'h3C);
    chk("R7 pix stop drops lock", {7'b0, pix_lock}, 8'h00);
    repeat (LOCK + 4) @(negedge clk);
    chk("R7 pix stays unlocked", {7'b0, pix_lock}, 8'h00);
    chk("R9 lp lock kept", {7'b0, lp_lock}, 8'h01);
    bus_wr(A_PTR, 8'h22);
    bus_rd(A_PIX, d); chk("R5 stopped P read", d, 8'h3C);
    bus_wr(A_LP, 8'h70);
    chk("R7 loop stop drops lock", {7'b0, lp_lock}, 8'h00);
    bus_rd(A_PTR, d); chk("R3 both wrapped", d, 8'h00);
  endtask

  task automatic t_restore_restart();
    bus_wr(A_PTR, 8'h00);
    bus_wr(A_PIX, 8'h12);
    bus_wr(A_PIX, 8'h34);
    bus_wr(A_PIX, 8'h05);
    lock_edge("R6 pix re-arm", 1'b1);
    bus_wr(A_PTR, 8'h00);
    bus_wr(A_PIX, 8'h77);
    chk("R8 N write drops lock", {7'b0, pix_lock}, 8'h00);
    chk("R11 new N", pix_n, 8'h77);
    lock_edge("R8 restart", 1'b1);
  endtask

  task automatic t_rsvd();
    logic [7:0] d;
    bus_wr(A_RSV, 8'hFF);
    bus_rd(A_RSV, d); chk("R10 reads zero", d, 8'h00);
    bus_rd(A_PTR, d); chk("R10 ptr unchanged", d, 8'h01);
    chk("R10 pix_n unchanged", pix_n, 8'h77);
    chk("R10 lp_p unchanged", lp_p, 8'h70);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pixel_program();
    t_ptr_fields();
    t_loop_iso();
    t_wrap();
    t_stop();
    t_restore_restart();
    t_rsvd();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule